// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash memory, working in 16-bit word addressing. It watches a synchronous bus-write strobe with its word address and data. It follows the multi-write unlock sequences that guard each operation. When a sequence completes, it issues a single-cycle request to the program/erase engine or to the read path. The requests are read/reset, autoselect, program, chip erase, and entering or leaving an unlock-bypass mode.

Each completed command produces a one-cycle pulse. The pulse carries an operation code and the address and data of the write that completed the command. Program and chip erase also set a busy flag, which stays set until the engine returns its done strobe. While the flag is set, every bus write is dropped. The block reports its current interface mode: read array, autoselect, or unlock bypass. Command bytes are taken from data bits 7:0, and the upper data bits do not affect decoding.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read array), `busy` is 0 and `op_valid` is 0.
- R2: A single write of F0h at any address, made with no sequence in progress, issues op code 1 (reset) and sets `mode` to 0. This also applies when `mode` is 1 (autoselect).
- R3: The writes AAh@555h, 55h@2AAh, 90h@555h issue op code 2 (autoselect) and set `mode` to 1.
- R4: The writes AAh@555h, 55h@2AAh, A0h@555h, followed by one more write at any address, issue op code 3 (program). The request carries the address and data of that fourth write, and `busy` is set in the same cycle as the pulse.
- R5: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h issue op code 4 (chip erase) and set `busy`.
- R6: The writes AAh@555h, 55h@2AAh, 20h@555h issue op code 5 (bypass entry) and set `mode` to 2.
- R7: When `mode` is 2, a write of A0h followed by one write at any address issues op code 3. The request carries the second write's address and data, and `mode` stays 2.
- R8: When `mode` is 2, a write of 90h followed by a write of 00h, both at any address, issue op code 6 (bypass exit) and set `mode` to 0.
- R9: A write that does not match the next expected step of any sequence issues no request and sets `mode` to 0. A later command must then start again from its first write.
- R10: While `busy` is 1, bus writes issue no request and leave the sequence state and `mode` unchanged. `busy` clears on the clock edge where `eng_done` is 1.
- R11: `op_valid` is high for exactly the one cycle after the clock edge that accepts a command's final write, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus-write strobe, one write per cycle when high |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data; bits 7:0 hold the command byte |
| eng_done | input | 1 | Program/erase engine finished |
| op_valid | output | 1 | One-cycle request pulse |
| op_code | output | 3 | 1 reset, 2 autoselect, 3 program, 4 chip erase, 5 bypass entry, 6 bypass exit |
| op_addr | output | ADDR_W | Address of the write that completed the command |
| op_data | output | DATA_W | Data of the write that completed the command |
| busy | output | 1 | Engine running; writes are dropped |
| mode | output | 2 | 0 read array, 1 autoselect, 2 unlock bypass |

## Verification
Some rules hold on every cycle, and the bound checker tests them. A busy cycle is never followed by a request, busy holds until done, and the mode stays frozen while busy. Every program or erase pulse coincides with busy set, each mode-changing operation leaves the matching mode, and no request follows a cycle without a write. The scenarios are needed to show which sequences are accepted, and with which address and data. They also show that a broken or wrong-address step produces nothing, and that bypass survives writes dropped during a bypass program.

// File: rtl/flash_cmd_pkg.sv
// Shared encodings for the flash command decoder.
// Assumes command bytes are carried on data bits 7:0.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_RESET     = 3'd1,
        OP_AUTOSEL   = 3'd2,
        OP_PROGRAM   = 3'd3,
        OP_ERASE     = 3'd4,
        OP_BYP_ENTER = 3'd5,
        OP_BYP_EXIT  = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_BYPASS  = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PGM_DATA,
        S_ERS1, S_ERS2, S_ERS3,
        S_BYP_IDLE, S_BYP_PGM, S_BYP_EXIT
    } seq_e;

    localparam logic [7:0] CMD_KEY1      = 8'hAA;
    localparam logic [7:0] CMD_KEY2      = 8'h55;
    localparam logic [7:0] CMD_RESET     = 8'hF0;
    localparam logic [7:0] CMD_AUTOSEL   = 8'h90;
    localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SET = 8'h80;
    localparam logic [7:0] CMD_CHIP_ERS  = 8'h10;
    localparam logic [7:0] CMD_BYPASS    = 8'h20;
    localparam logic [7:0] CMD_BYP_QUIT  = 8'h00;

endpackage

// File: rtl/flash_cmd_seq.sv
// Sequence tracker: steps through unlock prefixes and bypass sub-commands on
// each accepted write, and reports the operation completed by that write.
// Assumes 'accept' is already gated by the busy flag.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int KEY1_A = 'h555,
    parameter int KEY2_A = 'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd,
    output op_e               issue_op,
    output mode_e             mode
);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KEY1_A);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KEY2_A);

    seq_e  state, nxt_state;
    mode_e nxt_mode;
    logic  key1_ok, key2_ok;

    assign key1_ok = (cmd == CMD_KEY1) && (addr == A1);
    assign key2_ok = (cmd == CMD_KEY2) && (addr == A2);

    // Next state, next mode and completed operation for one accepted write.
    always_comb begin
        nxt_state = state;
        nxt_mode  = mode;
        issue_op  = OP_NONE;
        if (accept) begin
            nxt_state = S_IDLE;
            nxt_mode  = MODE_READ;
            unique case (state)
                S_IDLE: begin
                    if (cmd == CMD_RESET) begin
                        issue_op = OP_RESET;
                    end else if (key1_ok) begin
                        nxt_state = S_UNL1;
                        nxt_mode  = mode;
                    end
                end
                S_UNL1: if (key2_ok) begin
                    nxt_state = S_UNL2;
                    nxt_mode  = mode;
                end
                S_UNL2: if (addr == A1) begin
                    if (cmd == CMD_RESET) begin
                        issue_op = OP_RESET;
                    end else if (cmd == CMD_AUTOSEL) begin
                        issue_op = OP_AUTOSEL;
                        nxt_mode = MODE_AUTOSEL;
                    end else if (cmd == CMD_PROGRAM) begin
                        nxt_state = S_PGM_DATA;
                        nxt_mode  = mode;
                    end else if (cmd == CMD_ERASE_SET) begin
                        nxt_state = S_ERS1;
                        nxt_mode  = mode;
                    end else if (cmd == CMD_BYPASS) begin
                        issue_op  = OP_BYP_ENTER;
                        nxt_state = S_BYP_IDLE;
                        nxt_mode  = MODE_BYPASS;
                    end
                end
                S_PGM_DATA: issue_op = OP_PROGRAM;
                S_ERS1: if (key1_ok) begin
                    nxt_state = S_ERS2;
                    nxt_mode  = mode;
                end
                S_ERS2: if (key2_ok) begin
                    nxt_state = S_ERS3;
                    nxt_mode  = mode;
                end
                S_ERS3: if (cmd == CMD_CHIP_ERS && addr == A1) begin
                    issue_op = OP_ERASE;
                end
                S_BYP_IDLE: begin
                    if (cmd == CMD_PROGRAM) begin
                        nxt_state = S_BYP_PGM;
                        nxt_mode  = MODE_BYPASS;
                    end else if (cmd == CMD_AUTOSEL) begin
                        nxt_state = S_BYP_EXIT;
                        nxt_mode  = MODE_BYPASS;
                    end
                end
                S_BYP_PGM: begin
                    issue_op  = OP_PROGRAM;
                    nxt_state = S_BYP_IDLE;
                    nxt_mode  = MODE_BYPASS;
                end
                S_BYP_EXIT: if (cmd == CMD_BYP_QUIT) begin
                    issue_op = OP_BYP_EXIT;
                end
                default: ;
            endcase
        end
    end

    // Sequence state and interface mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            mode  <= MODE_READ;
        end else begin
            state <= nxt_state;
            mode  <= nxt_mode;
        end
    end

endmodule

// File: rtl/flash_cmd_busy.sv
// Engine busy flag: set when a program or erase is started, cleared by done.
// Assumes start can only occur while the flag is clear.
module flash_cmd_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic busy
);
    // Hold busy from engine start until the engine reports completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (done)  busy <= 1'b0;
    end
endmodule

// File: rtl/flash_cmd_issue.sv
// Request register: turns a completed operation into a one-cycle pulse that
// carries the completing write's address and data.
module flash_cmd_issue
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               issue_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              op_valid,
    output logic [2:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    // Register the pulse and code every cycle; payload only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_code  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= (issue_op != OP_NONE);
            op_code  <= issue_op;
            if (issue_op != OP_NONE) begin
                op_addr <= addr;
                op_data <= data;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder. Drops writes while the engine is busy,
// tracks command sequences and issues registered one-cycle requests.
// Assumes word (x16) addressing and one bus write per cycle.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_done,
    output logic              op_valid,
    output logic [2:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              busy,
    output logic [1:0]        mode
);
    logic  accept, eng_start;
    op_e   issue_op;
    mode_e cur_mode;

    assign accept    = wr_en && !busy;
    assign eng_start = (issue_op == OP_PROGRAM) || (issue_op == OP_ERASE);
    assign mode      = cur_mode;

    flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .addr(wr_addr),
        .cmd(wr_data[7:0]), .issue_op(issue_op), .mode(cur_mode)
    );

    flash_cmd_busy u_busy (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .done(eng_done), .busy(busy)
    );

    flash_cmd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .issue_op(issue_op), .addr(wr_addr),
        .data(wr_data), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_data(op_data)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
// Cycle-level rules of the command decoder, attached to every instance.
module flash_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       eng_done,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic       busy,
    input logic [1:0] mode
);
    AST_BUSY_BLOCKS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !op_valid);                                            // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !eng_done |=> busy);                                    // R10
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));                                        // R10
    AST_ENGINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 3'd3 || op_code == 3'd4) |-> busy);     // R4
    AST_NO_IDLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !op_valid);                                          // R11
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_code != 3'd0 && op_code != 3'd7));             // R11
    AST_AUTOSEL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 3'd2 |-> mode == 2'd1);                  // R3
    AST_BYPASS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 3'd5 |-> mode == 2'd2);                  // R6
    AST_READ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 3'd1 || op_code == 3'd6) |-> mode == 2'd0); // R8
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .eng_done(eng_done),
    .op_valid(op_valid), .op_code(op_code), .busy(busy), .mode(mode)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam logic [AW-1:0] K1 = 18'h555;
    localparam logic [AW-1:0] K2 = 18'h2AA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          eng_done = 1'b0;
    logic          op_valid, busy;
    logic [2:0]    op_code;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [1:0]    mode;

    typedef struct {
        string         req;
        logic [2:0]    code;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } exp_t;
    exp_t exp_q[$];

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_done(eng_done), .op_valid(op_valid),
        .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
        .busy(busy), .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_op(input string req, input logic [2:0] c,
                             input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        e.req = req; e.code = c; e.addr = a; e.data = d;
        exp_q.push_back(e);
    endtask

    // One bus write; the result is visible at the negedge where the task returns.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        bus_wr(K1, 16'h00AA);
        bus_wr(K2, 16'h0055);
    endtask

    task automatic engine_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    // Monitor: every request pulse must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && op_valid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R9/R11: unexpected request code %0d addr %0h data %0h, expected none",
                         op_code, op_addr, op_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.req, " code"}, 32'(op_code), 32'(e.code));
                chk({e.req, " addr"}, 32'(op_addr), 32'(e.addr));
                chk({e.req, " data"}, 32'(op_data), 32'(e.data));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", 32'(mode), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 op_valid", 32'(op_valid), 0);

        // R2: single-write reset
        expect_op("R2", 3'd1, 18'h01234, 16'h00F0);
        bus_wr(18'h01234, 16'h00F0);
        chk("R2 mode", 32'(mode), 0);

        // R3: autoselect, then a single F0 leaves it
        expect_op("R3", 3'd2, K1, 16'h0090);
        unlock(); bus_wr(K1, 16'h0090);
        chk("R3 mode", 32'(mode), 1);
        expect_op("R2 from autoselect", 3'd1, 18'h00010, 16'hFFF0);
        bus_wr(18'h00010, 16'hFFF0);
        chk("R2 mode after autoselect", 32'(mode), 0);

        // R4: four-write program, R10 writes ignored while busy
        unlock(); bus_wr(K1, 16'h00A0);
        expect_op("R4", 3'd3, 18'h30040, 16'hBEEF);
        bus_wr(18'h30040, 16'hBEEF);
        chk("R4 busy", 32'(busy), 1);
        bus_wr(K1, 16'h00F0);
        unlock();
        chk("R10 busy held", 32'(busy), 1);
        engine_done();
        chk("R10 busy cleared", 32'(busy), 0);

        // R5: six-write chip erase
        unlock(); bus_wr(K1, 16'h0080); unlock();
        expect_op("R5", 3'd4, K1, 16'h0010);
        bus_wr(K1, 16'h0010);
        chk("R5 busy", 32'(busy), 1);
        engine_done();

        // R9: broken sequences issue nothing
        unlock(); bus_wr(K1, 16'h0033);
        chk("R9 mode after bad code", 32'(mode), 0);
        bus_wr(K1, 16'h00A0); bus_wr(18'h01234, 16'h0000);
        bus_wr(K1, 16'h00AA); bus_wr(18'h002AB, 16'h0055); bus_wr(K1, 16'h0090);
        chk("R9 mode after bad address", 32'(mode), 0);
        unlock(); bus_wr(K1, 16'h0080); unlock(); bus_wr(K1, 16'h0030);
        chk("R9 busy after bad erase", 32'(busy), 0);
        expect_op("R9 recovery", 3'd2, K1, 16'h0090);
        unlock(); bus_wr(K1, 16'h0090);
        chk("R9 recovery mode", 32'(mode), 1);

        // R6: enter bypass
        expect_op("R6", 3'd5, K1, 16'h0020);
        unlock(); bus_wr(K1, 16'h0020);
        chk("R6 mode", 32'(mode), 2);

        // R7: two-write program in bypass; R10 ignored writes keep bypass
        bus_wr(18'h00000, 16'h00A0);
        expect_op("R7", 3'd3, 18'h10002, 16'h1111);
        bus_wr(18'h10002, 16'h1111);
        chk("R7 busy", 32'(busy), 1);
        bus_wr(18'h00000, 16'h0090); bus_wr(18'h00000, 16'h0000);
        chk("R10 mode kept while busy", 32'(mode), 2);
        engine_done();
        chk("R7 mode after program", 32'(mode), 2);
        bus_wr(18'h00007, 16'h00A0);
        expect_op("R7 second", 3'd3, 18'h22222, 16'h2222);
        bus_wr(18'h22222, 16'h2222);
        engine_done();

        // R8: leave bypass
        bus_wr(18'h00100, 16'h0090);
        expect_op("R8", 3'd6, 18'h00200, 16'h0000);
        bus_wr(18'h00200, 16'h0000);
        chk("R8 mode", 32'(mode), 0);
        bus_wr(18'h00000, 16'h00A0); bus_wr(18'h00004, 16'h4444);
        chk("R8 no bypass program", 32'(busy), 0);

        // R9: broken write inside bypass
        expect_op("R6 again", 3'd5, K1, 16'h0020);
        unlock(); bus_wr(K1, 16'h0020);
        bus_wr(18'h00000, 16'h0055);
        chk("R9 bypass dropped", 32'(mode), 0);

        repeat (4) @(negedge clk);
        chk("R11 all expected requests seen", 32'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule